// File: doc/BRIEF.md
# Serial DAC Word Receiver

This block is the receive front end of a current-output DAC. A host sends 16-bit words over three wires: an active-low frame select, a serial clock and a data line. The three lines are brought into a fast system clock through two-flop synchronizers, and serial clock edges are detected there. The system clock must run at least four times faster than the serial clock. A word counts as valid only when exactly sixteen sampling edges arrive while the frame is open. The upper four bits of a valid word are an opcode. One opcode writes the word into the DAC register. The others choose the sampling edge, turn cascading on or off, or ask for the DAC register to be returned on the next frame.

When cascading is on, the serial output sends out the word held from the previous frame while the new word comes in, most significant bit first. The output moves on the clock edge opposite to the one that samples the input. This lets several receivers share one chain, each word reaching the next device sixteen clocks later. A readback request drives the serial output for exactly one following frame, even with cascading off.

Top module: `sdac_rx`

## Requirements
- R1: A frame opens when frame_n falls and closes when it rises. Data bits arrive most significant first, bit 15 down to bit 0. A valid frame with opcode 4'h0 in bits 15:12 places all 16 bits on dac_word.
- R2: Each accepted write frame raises load for exactly one system clock cycle, after the frame closes.
- R3: A frame that closes after any number of sampling edges other than 16 (for example 15 or 17) leaves dac_word unchanged and raises no load.
- R4: After reset, dac_word is 0, load and ser_out are low, and sampling uses the falling edge of ser_clk.
- R5: A valid frame with opcode 4'hC sets the sampling edge from bit 0: 1 selects the rising edge and 0 the falling edge. The new edge applies from the next frame onward.
- R6: A valid frame with opcode 4'hD sets cascading from bit 0 (1 on, 0 off). While cascading is on, ser_out presents the previous frame's 16 received bits, most significant first, one bit per sampling edge. Each bit stays stable across the sampling edge and changes only on the opposite edge.
- R7: When cascading is off and no readback frame is in progress, ser_out stays low.
- R8: A valid frame with opcode 4'hE makes the next frame, and only that one, shift the current dac_word out on ser_out, most significant first, whatever the cascading setting.
- R9: A valid frame whose opcode is not 4'h0 changes neither dac_word nor load. Opcodes other than 4'h0, 4'hC, 4'hD and 4'hE have no effect at all.
- R10: ser_clk edges that occur while frame_n is high do not shift the receive register. A later cascaded frame therefore still presents the last complete word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame select (asynchronous) |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_in | input | 1 | Serial data input (asynchronous) |
| dac_word | output | 16 | Last accepted write word |
| load | output | 1 | One-cycle strobe when dac_word is updated |
| ser_out | output | 1 | Cascade / readback serial output |

## Verification
Several properties are checked on every cycle. The load strobe lasts a single cycle, and it only follows a frame close. dac_word never changes without that strobe. The bit counter stays within its saturation limit. The sampling and launch strobes never occur together. The serial output register only changes after a launch edge or a frame open. Only the bench scenarios can show the rest: sampling on the correct edge (the bench presents the inverse bit around the wrong edge), MSB-first word order, rejection of 15- and 17-bit frames, the sixteen-clock cascade delay with bits stable across the sampling edge in both edge modes, the one-shot readback, and stray clock edges outside a frame leaving the register alone.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 2);

  typedef enum logic [OP_W-1:0] {
    OP_WRITE = 4'h0,
    OP_EDGE  = 4'hC,
    OP_CHAIN = 4'hD,
    OP_RDBK  = 4'hE
  } op_e;

  function automatic logic [OP_W-1:0] op_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: OP_W];
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] n);
    return (n > CNT_W'(WORD_W)) ? n : n + 1'b1;
  endfunction

  function automatic logic len_ok(input logic [CNT_W-1:0] n);
    return n == CNT_W'(WORD_W);
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic frame_s,
  input  logic use_rise,
  output logic sample,
  launch,
  output logic frame_open,
  output logic frame_close,
  output logic in_frame
);
  logic sclk_d, frame_d, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      frame_d <= 1'b1;
    end else begin
      sclk_d  <= sclk_s;
      frame_d <= frame_s;
    end
  end

  assign rise        = sclk_s & ~sclk_d;
  assign fall        = ~sclk_s & sclk_d;
  assign in_frame    = ~frame_s;
  assign frame_open  = frame_d & ~frame_s;
  assign frame_close = ~frame_d & frame_s;
  assign sample      = in_frame & (use_rise ? rise : fall);
  assign launch      = in_frame & (use_rise ? fall : rise);

  // R6: sampling and launch strobes are never simultaneous
  p_edges_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample && launch));
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift import sdac_pkg::*; #(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         launch,
  input  logic         frame_open,
  input  logic         frame_close,
  input  logic         bit_in,
  input  logic         preload,
  input  logic [W-1:0] preload_val,
  output logic [W-1:0] rx_word,
  output logic         rx_ok,
  output logic         out_bit
);
  logic [W-1:0]     shreg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      out_bit <= 1'b0;
    end else if (frame_open) begin
      cnt <= '0;
      if (preload) begin
        shreg   <= preload_val;
        out_bit <= preload_val[W-1];
      end else begin
        out_bit <= shreg[W-1];
      end
    end else begin
      if (sample) begin
        shreg <= {shreg[W-2:0], bit_in};
        cnt   <= cnt_step(cnt);
      end
      if (launch) out_bit <= shreg[W-1];
    end
  end

  assign rx_word = shreg;
  assign rx_ok   = frame_close & len_ok(cnt);

  // R3: bit counter saturates just past a full word
  p_cnt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(W + 1));
  // R6: output bit moves only after a launch edge or a frame open
  p_out_on_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_bit) |-> $past(launch || frame_open));
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl import sdac_pkg::*; #(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_ok,
  input  logic [W-1:0] rx_word,
  input  logic         frame_open,
  input  logic         frame_close,
  output logic [W-1:0] dac_reg,
  output logic         load,
  output logic         use_rise,
  output logic         chain_en,
  output logic         rb_pend,
  output logic         rb_live
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_reg  <= '0;
      load     <= 1'b0;
      use_rise <= 1'b0;
      chain_en <= 1'b0;
      rb_pend  <= 1'b0;
      rb_live  <= 1'b0;
    end else begin
      load <= 1'b0;
      if (frame_open) begin
        rb_live <= rb_pend;
        rb_pend <= 1'b0;
      end
      if (frame_close) rb_live <= 1'b0;
      if (rx_ok) begin
        case (op_of(rx_word))
          OP_WRITE: begin
            dac_reg <= rx_word;
            load    <= 1'b1;
          end
          OP_EDGE:  use_rise <= rx_word[0];
          OP_CHAIN: chain_en <= rx_word[0];
          OP_RDBK:  rb_pend  <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  // R2: strobe lasts one cycle
  p_load_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
  // R9: register only changes together with the strobe
  p_dac_needs_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_reg) |-> load);
  // R8: a readback frame consumes its request
  p_rb_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rb_live |-> !rb_pend);
endmodule

// File: rtl/sdac_rx.sv
module sdac_rx import sdac_pkg::*; #(
  parameter int unsigned W           = WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_n,
  input  logic         ser_clk,
  input  logic         ser_in,
  output logic [W-1:0] dac_word,
  output logic         load,
  output logic         ser_out
);
  logic         frame_s, sclk_s, din_s;
  logic         sample, launch, frame_open, frame_close, in_frame;
  logic         use_rise, chain_en, rb_pend, rb_live;
  logic [W-1:0] rx_word;
  logic         rx_ok, out_bit;

  sdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({frame_n, ser_clk, ser_in}),
    .q({frame_s, sclk_s, din_s})
  );

  sdac_edge i_edge (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .frame_s(frame_s),
    .use_rise(use_rise), .sample(sample), .launch(launch),
    .frame_open(frame_open), .frame_close(frame_close), .in_frame(in_frame)
  );

  sdac_shift #(.W(W)) i_shift (
    .clk(clk), .rst_n(rst_n), .sample(sample), .launch(launch),
    .frame_open(frame_open), .frame_close(frame_close), .bit_in(din_s),
    .preload(rb_pend), .preload_val(dac_word),
    .rx_word(rx_word), .rx_ok(rx_ok), .out_bit(out_bit)
  );

  sdac_ctrl #(.W(W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_ok(rx_ok), .rx_word(rx_word),
    .frame_open(frame_open), .frame_close(frame_close),
    .dac_reg(dac_word), .load(load), .use_rise(use_rise),
    .chain_en(chain_en), .rb_pend(rb_pend), .rb_live(rb_live)
  );

  assign ser_out = (chain_en | rb_live) & out_bit;

  // R1/R2: a load follows a frame close
  p_load_after_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load) |-> $past(frame_close));
  // R10: no sampling strobe outside a frame
  p_no_sample_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |-> !sample);
endmodule

// File: tb/test_sdac_rx.sv
`timescale 1ns/1ps
module test_sdac_rx;
  logic clk = 0, rst_n = 0, frame_n = 1, ser_clk = 0, ser_in = 0;
  wire [15:0] dac_word;
  wire load, ser_out;

  int n_chk = 0, n_fail = 0, n_load = 0, unstable = 0;
  logic tb_rise = 0;
  logic [15:0] exp_dac = 0;
  logic [15:0] so;

  sdac_rx i_sdac_rx (.clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_clk(ser_clk),
    .ser_in(ser_in), .dac_word(dac_word), .load(load), .ser_out(ser_out));

  always #2 clk = ~clk;
  always @(posedge clk) if (load) n_load++;

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Sends nbits MSB first; the wrong edge sees the inverted bit.
  task automatic frame(input logic [15:0] w, input int nbits, input int q,
                       output logic [15:0] obs);
    logic b, pre;
    obs = 0; unstable = 0;
    frame_n = 0; wt(q);
    for (int i = 0; i < nbits; i++) begin
      b = (i < 16) ? w[15-i] : 1'b0;
      ser_in = tb_rise ? b : ~b; wt(q);
      if (tb_rise) pre = ser_out;
      ser_clk = 1; wt(q);
      if (tb_rise && ser_out !== pre) unstable++;
      ser_in = tb_rise ? ~b : b; wt(q);
      if (!tb_rise) pre = ser_out;
      ser_clk = 0; wt(q);
      if (!tb_rise && ser_out !== pre) unstable++;
      if (i < 16) obs = {obs[14:0], pre};
    end
    wt(q); frame_n = 1; wt(4 * q);
  endtask

  task automatic t_reset;
    chk("R4 dac after reset", dac_word, 0);
    chk("R4 load after reset", load, 0);
    chk("R4 ser_out after reset", ser_out, 0);
  endtask

  task automatic t_write;
    int l0 = n_load;
    frame(16'h0ABC, 16, 4, so); exp_dac = 16'h0ABC;
    chk("R1 write 0ABC", dac_word, exp_dac);
    chk("R2 one load", n_load - l0, 1);
    chk("R7 ser_out low standalone", so, 0);
    frame(16'h0555, 16, 4, so); exp_dac = 16'h0555;
    chk("R1 write 0555", dac_word, exp_dac);
    chk("R2 second load", n_load - l0, 2);
  endtask

  task automatic t_length;
    int l0 = n_load;
    frame(16'h0123, 15, 4, so);
    chk("R3 15-bit dac", dac_word, exp_dac);
    frame(16'h0321, 17, 4, so);
    chk("R3 17-bit dac", dac_word, exp_dac);
    chk("R3 no load", n_load - l0, 0);
  endtask

  task automatic t_ignored;
    int l0 = n_load;
    frame(16'h7FFF, 16, 4, so);
    chk("R9 unknown op dac", dac_word, exp_dac);
    frame(16'hD000, 16, 4, so);
    chk("R9 config op dac", dac_word, exp_dac);
    chk("R9 no load", n_load - l0, 0);
  endtask

  task automatic t_edge;
    frame(16'hC001, 16, 4, so); tb_rise = 1;
    frame(16'h0321, 16, 4, so); exp_dac = 16'h0321;
    chk("R5 rising-edge write", dac_word, exp_dac);
    frame(16'hC000, 16, 4, so); tb_rise = 0;
    frame(16'h0246, 16, 4, so); exp_dac = 16'h0246;
    chk("R5 back to falling write", dac_word, exp_dac);
  endtask

  task automatic t_chain;
    frame(16'hD001, 16, 8, so);
    frame(16'h0F0F, 16, 8, so); exp_dac = 16'h0F0F;
    chk("R6 cascade word", so, 16'hD001);
    chk("R6 bits stable at sample", unstable, 0);
    chk("R1 write in cascade", dac_word, exp_dac);
    frame(16'h7A5A, 16, 8, so);
    chk("R6 cascade second", so, 16'h0F0F);
    for (int k = 0; k < 3; k++) begin
      ser_in = 1; ser_clk = 1; wt(8); ser_clk = 0; wt(8);
    end
    frame(16'hD000, 16, 8, so);
    chk("R10 idle edges ignored", so, 16'h7A5A);
    frame(16'h0100, 16, 8, so); exp_dac = 16'h0100;
    chk("R7 low after cascade off", so, 0);
  endtask

  task automatic t_readback;
    frame(16'hE000, 16, 8, so);
    frame(16'h7000, 16, 8, so);
    chk("R8 readback word", so, exp_dac);
    frame(16'h7000, 16, 8, so);
    chk("R8 readback one-shot", so, 0);
  endtask

  task automatic t_chain_rise;
    frame(16'hC001, 16, 8, so); tb_rise = 1;
    frame(16'hD001, 16, 8, so);
    frame(16'h0333, 16, 8, so); exp_dac = 16'h0333;
    chk("R6 rising cascade word", so, 16'hD001);
    chk("R6 rising bits stable", unstable, 0);
    chk("R5 rising dac", dac_word, exp_dac);
    frame(16'hD000, 16, 8, so);
    chk("R6 rising cascade second", so, 16'h0333);
    frame(16'hC000, 16, 8, so); tb_rise = 0;
  endtask

  initial begin
    wt(5); rst_n = 1; wt(5);
    t_reset();
    t_write();
    t_length();
    t_ignored();
    t_edge();
    t_chain();
    t_readback();
    t_chain_rise();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule